// File: doc/BRIEF.md
# Cell-Start Handshake Transmit Port

This block is the core-side receiving end of a narrow cell transmit interface. Fabric logic pushes fixed-size cells into a core FIFO over a 40-bit data bus, which carries five octets per clock. The core grants the start of each cell with a one-cycle permit strobe. While the port is idle and the FIFO has room, that strobe repeats every four cycles. The user answers a permit with a one-cycle valid pulse on the very next cycle. It then streams the cell one beat per cycle, starting on the cycle after the valid pulse.

The block counts beats against the selected cell size. It forwards each beat to the FIFO write port and zero-fills the unused octets of the final beat. Any valid pulse that breaks the handshake is rejected and recorded in a sticky error flag.

Top module: `cell_start_rx`

## Requirements
- R1: While reset is asserted (`rst_n` low), `permit`, `fifo_wr` and `proto_err` are low. After reset is released with `fifo_room` high, `permit` is high in the first cycle.
- R2: `permit` is never high in a cycle where `fifo_room` is low.
- R3: While idle with `fifo_room` high and no valid pulse, `permit` is high for one cycle out of every four.
- R4: A `valid` pulse in the cycle right after a `permit` cycle starts a cell. `fifo_wr` is high for one beat per cycle, starting in the next cycle, and `fifo_data` carries `din` during those beats.
- R5: `size_sel` is sampled when a cell starts and selects the cell size: 0 gives 75 octets (15 beats), 1 gives 79 (16), 2 gives 83 (17) and 3 gives 91 (19). The beat count is the size divided by 5, rounded up.
- R6: Octet k of a beat sits at `din[39-8k:32-8k]`, and octet 0 comes first. On the last beat, only the octets that remain in the cell pass through, and the lower unused octets are written as zero.
- R7: A `valid` pulse that does not follow a `permit` cycle does not start a cell and produces no write. It sets `proto_err`, which stays high until reset.
- R8: `permit` stays low during a burst. When `fifo_room` is high, it is high again in the cycle right after the last beat.
- R9: A `valid` pulse during a burst sets `proto_err` and does not change the burst's beat count or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| size_sel | input | 2 | Cell size select |
| fifo_room | input | 1 | Core FIFO can accept another cell |
| valid | input | 1 | User cell-start pulse |
| din | input | 40 | Cell data beat |
| permit | output | 1 | Cell-start permit strobe |
| fifo_wr | output | 1 | FIFO write enable |
| fifo_data | output | 40 | FIFO write data, last beat padded |
| proto_err | output | 1 | Sticky handshake error |

## Verification
On every cycle, the assertions check the following:
- permit never appears without room and never repeats within three cycles;
- no permit appears during a burst;
- an accepted valid always leads to a write on the next cycle;
- a stray valid always sets the error flag, and the flag never clears by itself.

Some behaviours only the bench scenarios can show. These are the exact beat count for each size select, the zero padding of the final beat, the return of the permit right after the last beat, and that a valid pulse during a burst leaves the burst's data untouched.

// File: rtl/cell_start_rx.sv
module cell_start_rx #(
  parameter int W  = 40,
  parameter int PW = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   size_sel,
  input  logic         fifo_room,
  input  logic         valid,
  input  logic [W-1:0] din,
  output logic         permit,
  output logic         fifo_wr,
  output logic [W-1:0] fifo_data,
  output logic         proto_err
);
  localparam int NB = W / 8;
  localparam int CW = $clog2(91 / NB + 2);

  function automatic int cell_octets(input logic [1:0] s);
    case (s)
      2'd0:    return 75;
      2'd1:    return 79;
      2'd2:    return 83;
      default: return 91;
    endcase
  endfunction

  logic          busy, permit_q;
  logic [PW-1:0] ph;
  logic [CW-1:0] cnt;
  logic [1:0]    sel_q;
  int            octets, nbeats, used;
  logic          last, accept;

  assign octets  = cell_octets(sel_q);
  assign nbeats  = (octets + NB - 1) / NB;
  assign used    = octets - NB * (nbeats - 1);
  assign last    = busy && (cnt == CW'(nbeats - 1));
  assign permit  = rst_n && !busy && fifo_room && (ph == '0);
  assign accept  = valid && permit_q && !busy;
  assign fifo_wr = busy;

  always_comb begin
    for (int k = 0; k < NB; k++)
      fifo_data[W-1-8*k -: 8] = (busy && (!last || k < used)) ? din[W-1-8*k -: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      permit_q  <= 1'b0;
      ph        <= '0;
      cnt       <= '0;
      sel_q     <= 2'd0;
      proto_err <= 1'b0;
    end else begin
      permit_q <= permit;
      if (valid && !accept) proto_err <= 1'b1;
      if (busy) begin
        if (last) begin
          busy <= 1'b0;
          ph   <= '0;
          cnt  <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end else if (accept) begin
        busy  <= 1'b1;
        cnt   <= '0;
        sel_q <= size_sel;
      end else begin
        ph <= ph + 1'b1;
      end
    end
  end
endmodule

module cell_start_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic fifo_room,
  input logic valid,
  input logic permit,
  input logic fifo_wr,
  input logic proto_err
);
  a_r2_room_gates_permit: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> fifo_room);
  a_r3_permit_gap: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> (!$past(permit) && !$past(permit, 2) && !$past(permit, 3)));
  a_r4_accept_writes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(permit) && !fifo_wr) |=> fifo_wr);
  a_r7_stray_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !$past(permit)) |=> proto_err);
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r8_quiet_burst: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !permit);
endmodule

bind cell_start_rx cell_start_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_room(fifo_room), .valid(valid),
  .permit(permit), .fifo_wr(fifo_wr), .proto_err(proto_err)
);

// File: tb/cell_start_rx_test.sv
module cell_start_rx_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  size_sel = 2'd0;
  logic        fifo_room = 1'b1;
  logic        valid = 1'b0;
  logic [39:0] din = '0;
  logic        permit, fifo_wr, proto_err;
  logic [39:0] fifo_data;
  int checks = 0, errors = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  cell_start_rx uut (
    .clk(clk), .rst_n(rst_n), .size_sel(size_sel), .fifo_room(fifo_room),
    .valid(valid), .din(din), .permit(permit), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .proto_err(proto_err)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] beat(input int i);
    return {8'hC3 ^ 8'(i), 8'h5A, 8'hA5, 8'h3C, 8'(i + 1)};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; valid = 1'b0; fifo_room = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 permit in reset", permit, 0);
    chk("R1 wr in reset", fifo_wr, 0);
    chk("R1 err in reset", proto_err, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 first permit", permit, 1);
  endtask

  task automatic t_period();
    t_reset();
    for (int i = 0; i < 12; i++) begin
      chk("R3 permit period", permit, (i % 4 == 0));
      @(negedge clk); #1;
    end
  endtask

  task automatic t_noroom();
    int seen = 0;
    fifo_room = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk); #1;
      if (permit) seen++;
    end
    chk("R2 no permit without room", seen, 0);
    fifo_room = 1'b1;
  endtask

  task automatic wait_permit();
    for (int i = 0; i < 8 && !permit; i++) begin
      @(negedge clk); #1;
    end
    chk("R3 permit seen", permit, 1);
  endtask

  task automatic t_cell(input logic [1:0] sel, input int nbeats, input int used, input bit stray);
    logic [39:0] exp;
    wait_permit();
    @(negedge clk);
    valid = 1'b1; size_sel = sel; #1;
    chk("R4 no write on valid cycle", fifo_wr, 0);
    @(negedge clk);
    valid = 1'b0; size_sel = ~sel;
    for (int i = 0; i < nbeats; i++) begin
      din = beat(i);
      valid = stray && (i == 3);
      #1;
      exp = beat(i);
      if (i == nbeats - 1) exp = exp & ({40{1'b1}} << (8 * (5 - used)));
      chk(stray ? "R9 beat write" : "R4 beat write", fifo_wr, 1);
      chk(i == nbeats - 1 ? "R6 last beat pad" : "R5 beat data", fifo_data, exp);
      chk("R8 no permit in burst", permit, 0);
      @(negedge clk);
      valid = 1'b0;
    end
    #1;
    chk("R5 burst ends", fifo_wr, 0);
    chk("R8 permit after burst", permit, 1);
    if (stray) chk("R9 err on valid in burst", proto_err, 1);
  endtask

  task automatic t_stray();
    int wr = 0;
    t_reset();
    @(negedge clk); @(negedge clk);
    valid = 1'b1;
    @(negedge clk);
    valid = 1'b0; #1;
    chk("R7 err set", proto_err, 1);
    for (int i = 0; i < 6; i++) begin
      if (fifo_wr) wr++;
      @(negedge clk); #1;
    end
    chk("R7 stray ignored", wr, 0);
    t_cell(2'd1, 16, 4, 0);
    chk("R7 err sticky", proto_err, 1);
  endtask

  initial begin
    t_period();
    t_noroom();
    t_cell(2'd0, 15, 5, 0);
    t_cell(2'd1, 16, 4, 0);
    t_cell(2'd2, 17, 3, 0);
    t_cell(2'd3, 19, 1, 0);
    chk("R4 clean handshakes no err", proto_err, 0);
    t_stray();
    t_reset();
    chk("R1 reset clears err", proto_err, 0);
    t_cell(2'd3, 19, 1, 1);
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule